// File: doc/BRIEF.md
# Dual-Device Clock-Chip Serial Configuration Master

This block lets a host configure two clock-distribution chips. The chips share one serial clock and one outgoing data line, and each chip has its own chip select and its own return line. The host hands over a 20-bit command word on a valid/ready channel. The command word holds a data byte, a 7-bit register address, a 2-bit byte-count field, a read flag and two device-select bits. Each accepted command runs exactly one 24-bit frame. The frame is a 16-bit instruction followed by one data byte. When the frame is a read, the byte each selected chip returns is captured into that chip's own byte lane of a 32-bit receive word.

A small configuration register holds two settings. The first is the serial-clock divider code. The second is one active-low reset line for each chip. Reading the register returns these settings together with a 16-bit status input from the clock module. The command channel applies back-pressure by holding `cmd_ready` low for the whole frame. A command presented while ready is low is neither taken nor queued, and the source may change or withdraw it freely. A transfer happens on a rising edge where `cmd_valid` and `cmd_ready` are both high.

Top module: `clkdist_spi_master`

## Requirements
- R1: The divider code D (configuration bits [1:0]) is captured when a command is accepted. Each serial-clock half period then lasts 2^D bus-clock cycles, so code 0 gives half the bus clock and each higher code halves the rate again. Changing the code during a frame does not affect that frame.
- R2: A frame is 24 bits sent MSB first on `mosi`, in this order: the read flag (command bit 17; 1 = read, 0 = write), the byte-count field (command bits [16:15], sent as given), six zero bits, the address (command bits [14:8]) and the data byte (command bits [7:0]). `mosi` is 0 while idle.
- R3: `sclk` idles low and makes 24 pulses. `mosi` changes only on falling edges. The first bit is already valid when the chip selects assert. The return lines are sampled on rising edges.
- R4: `cs_n[d]` is active low and asserts for the frame when select bit 18+d of the command is set. Both selects may assert together. The selects assert on the acceptance cycle, one half period before the first rising edge, and release one half period after the last falling edge.
- R5: `cmd_ready` is high exactly when no frame is in progress. It goes low on the acceptance cycle and returns high on the cycle the selects release. A command offered while ready is low has no effect on any output.
- R6: On a read, each selected chip's lane receives the last 8 bits sampled from `miso[d]`, MSB first. Chip 0 uses `rx_word[7:0]` and chip 1 uses `rx_word[15:8]`. The lane updates on the cycle the selects release. An unselected lane keeps its value, and `rx_word[31:16]` is always zero.
- R7: A write frame leaves `rx_word` unchanged.
- R8: `cfg_wr` loads `cfg_wdata[1:0]` as the divider code, `cfg_wdata[2]` into `dev_rst_n[0]` and `cfg_wdata[3]` into `dev_rst_n[1]`. After reset all of these are zero, so both chips are held in reset.
- R9: `cfg_rdata` holds the configuration in bits [3:0], zeros in bits [15:4], and the live `status_in` value in bits [31:16].
- R10: After reset the outputs are as follows: `cs_n` is all ones, `sclk` and `mosi` are 0, `cmd_ready` is 1 and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Divider code and chip reset levels |
| cfg_rdata | output | 32 | Status input, zero padding and configuration |
| status_in | input | 16 | Clock-module status |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_data | input | 20 | Command word |
| rx_word | output | 32 | Captured read bytes, one lane per chip |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the chips |
| cs_n | output | 2 | Active-low chip selects |
| miso | input | 2 | Serial data from each chip |
| dev_rst_n | output | 2 | Active-low chip resets |

## Verification
The properties assume that reset is asserted from time zero and that every input is at a known level once reset is released. They also assume that a configuration write never lands on the same rising edge that accepts a command. The bench keeps to these assumptions. It applies reset before the first clock edge and changes every input a fixed delay after a rising edge. It issues configuration writes only while the master is idle and no command is offered, or in the middle of a frame. It also drives both return lines with defined levels throughout, including during the instruction bits, where they carry ones that must not reach the captured lanes.

// File: rtl/clkspi_pkg.sv
package clkspi_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 7;
  localparam int CNT_W   = 2;
  localparam int INSTR_W = 16;
  localparam int PAD_W   = INSTR_W - 1 - CNT_W - ADDR_W;
  localparam int FRAME_W = INSTR_W + DATA_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_HIGH  = 2'd2,
    ST_TRAIL = 2'd3
  } spi_state_e;

  function automatic logic [FRAME_W-1:0] make_frame(
    input logic              rd,
    input logic [CNT_W-1:0]  cnt,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data
  );
    return {rd, cnt, {PAD_W{1'b0}}, addr, data};
  endfunction
endpackage

// File: rtl/clkspi_tick.sv
module clkspi_tick #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] sel,
  output logic             tick
);
  localparam int CW = 1 << DIV_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim  = (CW'(1) << sel) - CW'(1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else if (run)      cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/clkspi_ctrl.sv
module clkspi_ctrl
  import clkspi_pkg::*;
#(
  parameter int NUM_DEV = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [NUM_DEV-1:0] mask,
  input  logic               tick,
  output logic               busy,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_DEV-1:0] cs_n,
  output logic               sample,
  output logic               done,
  output logic               rd_q
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(FRAME_W - 1);

  spi_state_e         state_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_W-1:0]   bit_q;

  assign busy   = (state_q != ST_IDLE);
  assign mosi   = busy & sh_q[FRAME_W-1];
  assign sample = tick && (state_q == ST_LOW);
  assign done   = tick && (state_q == ST_TRAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      sclk    <= 1'b0;
      cs_n    <= '1;
      rd_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOW;
          sh_q    <= frame;
          bit_q   <= '0;
          cs_n    <= ~mask;
          rd_q    <= frame[FRAME_W-1];
        end
        ST_LOW: if (tick) begin
          sclk    <= 1'b1;
          state_q <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (bit_q == LAST) begin
            state_q <= ST_TRAIL;
          end else begin
            bit_q   <= bit_q + BIT_W'(1);
            sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
            state_q <= ST_LOW;
          end
        end
        ST_TRAIL: if (tick) begin
          cs_n    <= '1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkspi_rx.sv
module clkspi_rx #(
  parameter int NUM_DEV = 2,
  parameter int DATA_W  = 8,
  parameter int RX_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample,
  input  logic               done,
  input  logic               rd,
  input  logic [NUM_DEV-1:0] sel,
  input  logic [NUM_DEV-1:0] miso,
  output logic [RX_W-1:0]    rx_word
);
  localparam int USED_W = NUM_DEV * DATA_W;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_lane
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        lane_q <= '0;
      end else begin
        if (sample) sh_q <= {sh_q[DATA_W-2:0], miso[d]};
        if (done && rd && sel[d]) lane_q <= sh_q;
      end
    end

    assign rx_word[d*DATA_W +: DATA_W] = lane_q;
  end

  if (RX_W > USED_W) begin : g_pad
    assign rx_word[RX_W-1:USED_W] = '0;
  end
endmodule

// File: rtl/clkdist_spi_master.sv
module clkdist_spi_master
  import clkspi_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int DIV_W   = 2,
  parameter int STAT_W  = 16,
  parameter int RX_W    = 32,
  localparam int CFG_W  = DIV_W + NUM_DEV,
  localparam int CMD_W  = DATA_W + ADDR_W + CNT_W + 1 + NUM_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [RX_W-1:0]    cfg_rdata,
  input  logic [STAT_W-1:0]  status_in,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [CMD_W-1:0]   cmd_data,
  output logic [RX_W-1:0]    rx_word,
  output logic               sclk,
  output logic               mosi,
  output logic [NUM_DEV-1:0] cs_n,
  input  logic [NUM_DEV-1:0] miso,
  output logic [NUM_DEV-1:0] dev_rst_n
);
  localparam int A_LO = DATA_W;
  localparam int C_LO = A_LO + ADDR_W;
  localparam int R_B  = C_LO + CNT_W;
  localparam int M_LO = R_B + 1;
  localparam int PADR = RX_W - STAT_W - CFG_W;

  logic [DIV_W-1:0] div_q, div_run_q;
  logic busy, start, tick, sample, done, xfer_rd;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      dev_rst_n <= '0;
    end else if (cfg_wr) begin
      div_q     <= cfg_wdata[DIV_W-1:0];
      dev_rst_n <= cfg_wdata[CFG_W-1:DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_run_q <= '0;
    else if (start) div_run_q <= div_q;
  end

  assign cfg_rdata = {status_in, {PADR{1'b0}}, dev_rst_n, div_q};
  assign cmd_ready = !busy;
  assign start     = cmd_valid && cmd_ready;
  assign frame     = make_frame(cmd_data[R_B], cmd_data[R_B-1:C_LO],
                                cmd_data[C_LO-1:A_LO], cmd_data[A_LO-1:0]);

  clkspi_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(busy),
    .sel(div_run_q), .tick(tick)
  );

  clkspi_ctrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .frame(frame),
    .mask(cmd_data[M_LO +: NUM_DEV]), .tick(tick), .busy(busy),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .sample(sample),
    .done(done), .rd_q(xfer_rd)
  );

  clkspi_rx #(.NUM_DEV(NUM_DEV), .DATA_W(DATA_W), .RX_W(RX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(sample), .done(done),
    .rd(xfer_rd), .sel(~cs_n), .miso(miso), .rx_word(rx_word)
  );
endmodule

// File: rtl/clkspi_checker.sv
module clkspi_checker #(
  parameter int NUM_DEV = 2,
  parameter int RX_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               cmd_ready,
  input logic               sclk,
  input logic               mosi,
  input logic [NUM_DEV-1:0] cs_n,
  input logic [RX_W-1:0]    rx_word,
  input logic [NUM_DEV-1:0] dev_rst_n,
  input logic               cfg_wr,
  input logic               xfer_rd
);
  // R3: the serial clock rests low outside a frame
  p_sclk_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R4: no select is held while idle
  p_cs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (&cs_n));

  // R5: while not ready the selects either hold or release, never swap
  p_cs_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> ($stable(cs_n) || (&cs_n)));

  // R2: mosi is quiet while idle
  p_mosi_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !mosi);

  // R6: upper half of the receive word stays zero
  p_rx_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_word[RX_W-1:16] == '0);

  // R6: the receive word cannot move out of an idle cycle
  p_rx_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rx_word));

  // R7: a write frame never alters the receive word
  p_rx_write_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_rd) |=> $stable(rx_word));

  // R8: the chip resets move only on a configuration write
  p_rst_only_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(dev_rst_n));
endmodule

bind clkdist_spi_master clkspi_checker #(.NUM_DEV(NUM_DEV), .RX_W(RX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_ready(cmd_ready),
  .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .rx_word(rx_word),
  .dev_rst_n(dev_rst_n), .cfg_wr(cfg_wr), .xfer_rd(xfer_rd)
);

// File: tb/tb_clkdist_spi_master.sv
`timescale 1ns/1ps
module tb_clkdist_spi_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] status_in = 16'h0000;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [19:0] cmd_data = '0;
  logic [31:0] rx_word;
  logic        sclk, mosi;
  logic [1:0]  cs_n, miso, dev_rst_n;
  logic [7:0]  resp0 = 8'h00, resp1 = 8'h00;

  int errors = 0, checks = 0, cycles = 0;

  always #4 clk = ~clk;

  clkdist_spi_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .status_in(status_in), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .rx_word(rx_word),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso), .dev_rst_n(dev_rst_n)
  );

  // ---------------- behavioural reference ----------------
  int          m_t = 0, m_h = 1;
  logic        m_busy = 1'b0, m_rd = 1'b0;
  logic [1:0]  m_div = '0, m_rst = '0, m_mask = '0;
  logic [23:0] m_frame = '0;
  logic [31:0] m_rx = '0;

  function automatic int bit_idx();
    int j = m_t / (2 * m_h);
    return (j > 23) ? 23 : j;
  endfunction

  assign miso[0] = (m_busy && bit_idx() >= 16) ? resp0[23 - bit_idx()] : 1'b1;
  assign miso[1] = (m_busy && bit_idx() >= 16) ? resp1[23 - bit_idx()] : 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_t <= 0; m_h <= 1; m_div <= '0; m_rst <= '0;
      m_rx <= '0; m_rd <= 1'b0; m_mask <= '0; m_frame <= '0;
    end else begin
      if (cfg_wr) begin m_div <= cfg_wdata[1:0]; m_rst <= cfg_wdata[3:2]; end
      if (!m_busy) begin
        if (cmd_valid) begin
          m_busy  <= 1'b1; m_t <= 0; m_h <= 1 << m_div;
          m_rd    <= cmd_data[17]; m_mask <= cmd_data[19:18];
          m_frame <= {cmd_data[17], cmd_data[16:15], 6'b0, cmd_data[14:8], cmd_data[7:0]};
        end
      end else if (m_t + 1 == 49 * m_h) begin
        m_busy <= 1'b0;
        if (m_rd && m_mask[0]) m_rx[7:0]  <= resp0;
        if (m_rd && m_mask[1]) m_rx[15:8] <= resp1;
      end else begin
        m_t <= m_t + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  logic [1:0] e_cs;
  logic       e_sclk, e_mosi;
  always @(negedge clk) if (rst_n) begin
    e_cs   = m_busy ? ~m_mask : 2'b11;
    e_sclk = m_busy && (m_t < 48 * m_h) && (((m_t / m_h) % 2) == 1);
    e_mosi = m_busy ? m_frame[23 - bit_idx()] : 1'b0;
    check("R4 cs_n", {30'd0, cs_n}, {30'd0, e_cs});
    check("R1/R3 sclk", {31'd0, sclk}, {31'd0, e_sclk});
    check("R2 mosi", {31'd0, mosi}, {31'd0, e_mosi});
    check("R5 cmd_ready", {31'd0, cmd_ready}, {31'd0, !m_busy});
    check(m_rd ? "R6 rx_word" : "R7 rx_word", rx_word, m_rx);
    check("R8 dev_rst_n", {30'd0, dev_rst_n}, {30'd0, m_rst});
    check("R9 cfg_rdata", cfg_rdata, {status_in, 12'd0, m_rst, m_div});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cfg(input logic [3:0] v);
    @(posedge clk); #2 cfg_wr = 1'b1; cfg_wdata = v;
    @(posedge clk); #2 cfg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) begin @(posedge clk); #2; end
  endtask

  task automatic run_cmd(input logic [1:0] m, input logic rd, input logic [1:0] cnt,
                         input logic [6:0] a, input logic [7:0] d);
    @(posedge clk); #2 cmd_valid = 1'b1; cmd_data = {m, rd, cnt, a, d};
    @(posedge clk); #2 cmd_valid = 1'b0;
    wait_idle();
  endtask

  initial begin
    #20;
    @(negedge clk);
    // R10: outputs right after reset, sampled while still in reset
    check("R10 cs_n", {30'd0, cs_n}, 32'h3);
    check("R10 sclk", {31'd0, sclk}, 32'h0);
    check("R10 mosi", {31'd0, mosi}, 32'h0);
    check("R10 cmd_ready", {31'd0, cmd_ready}, 32'h1);
    check("R10 rx_word", rx_word, 32'h0);
    check("R8 reset level", {30'd0, dev_rst_n}, 32'h0);
    rst_n = 1'b1;

    status_in = 16'hBEEF;
    cfg(4'b1100);                                // R8 release both, D=0
    // R2 R3 R4 R7: write to chip 0 at the fastest rate
    run_cmd(2'b01, 1'b0, 2'b00, 7'h55, 8'hC3);
    check("R7 rx after write", rx_word, 32'h0);
    // R6: read both chips, D=1
    resp0 = 8'h3C; resp1 = 8'hA7;
    cfg(4'b1101);
    run_cmd(2'b11, 1'b1, 2'b00, 7'h12, 8'h00);
    check("R6 both lanes", rx_word, 32'h0000A73C);
    // R6: read chip 1 only, D=2; lane 0 must keep 3C
    resp0 = 8'hFF; resp1 = 8'h5A;
    cfg(4'b0110);
    run_cmd(2'b10, 1'b1, 2'b00, 7'h7F, 8'h81);
    check("R6 unselected lane kept", rx_word, 32'h00005A3C);
    // R5 R7 R1: write both at D=3 with stray offers and a divider change mid-frame
    resp0 = 8'h11; resp1 = 8'h22;
    cfg(4'b1111);
    @(posedge clk); #2 cmd_valid = 1'b1; cmd_data = {2'b11, 1'b0, 2'b00, 7'h2A, 8'h96};
    @(posedge clk); #2 cmd_data = {2'b01, 1'b1, 2'b01, 7'h01, 8'h01};
    repeat (30) @(posedge clk);
    #2 cmd_valid = 1'b0; cfg_wr = 1'b1; cfg_wdata = 4'b1100;
    @(posedge clk); #2 cfg_wr = 1'b0;
    wait_idle();
    check("R7 rx after write", rx_word, 32'h00005A3C);
    // R5: back-to-back, valid held across the ready edge; R2 non-zero count sent as given
    resp0 = 8'h0F; resp1 = 8'hF0;
    @(posedge clk); #2 cmd_valid = 1'b1; cmd_data = {2'b01, 1'b1, 2'b10, 7'h40, 8'hE7};
    @(posedge clk); #2;
    wait_idle();
    cmd_data = {2'b11, 1'b1, 2'b00, 7'h03, 8'h00};
    @(posedge clk); #2 cmd_valid = 1'b0;
    wait_idle();
    check("R6 back-to-back read", rx_word, 32'h0000F00F);
    // R4: no chip selected still clocks a frame, rx untouched
    run_cmd(2'b00, 1'b1, 2'b00, 7'h09, 8'h00);
    check("R6 no lane selected", rx_word, 32'h0000F00F);
    // R9: live status
    @(posedge clk); #2 status_in = 16'h1234;
    @(negedge clk);
    check("R9 status", cfg_rdata, {16'h1234, 12'd0, 4'b1100});
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule